// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host with an 8-bit data bus access to a 20-bit internal register space through a small window of external addresses. The host loads an internal address into a pointer register. Three byte-wide staging registers together hold one internal word. Writing the lowest staging register commits the assembled word to the selected internal location. Reading it fetches the word at that location, and the same fetch refreshes the two upper staging registers. The host then reads those two registers to get the rest of the word.

A single bit in a control register chooses the internal map that an access reaches. One map is a wide channel map and the other is a small output-port map. Each map is modelled by its own internal memory bank. Because the order of accesses is fixed, a write sequence always ends on the low data register and a read sequence always starts on it.

Top module: `idx_port`

## Requirements
- R1: After reset, reads of the pointer (external address 6), the control register (3), and data registers 1 and 2 all return 0x00. hst_rdata is also 0x00.
- R2: The external map is as follows: data register 0 at address 0, data register 1 at 1, data register 2 at 2, control at 3, pointer at 6. Reads of addresses 4, 5 and 7 return 0x00, and writes to them change no state.
- R3: Data register 2 stores only hst_wdata[3:0]. A read of it returns the stored nibble in bits [3:0] and zero in bits [7:4].
- R4: A write to address 0 commits the word {DR2[3:0], DR1[7:0], hst_wdata[7:0]} to the internal location selected by the pointer, in the map selected by the control bit.
- R5: Writes to addresses 1 and 2 only stage data and leave every internal location unchanged.
- R6: A read of address 0 returns bits [7:0] of the selected internal word. On the same clock edge it loads bits [15:8] into DR1 and bits [19:16] into DR2, and later reads of addresses 1 and 2 return them.
- R7: Staging registers keep their value until they are written or refreshed by a fetch. A write to address 0 alone therefore commits the previously staged upper bits, which serves narrow internal words.
- R8: Bit 5 of the control register selects the output-port map (1) or the channel map (0). The other control bits read as 0. The two maps are independent, and the output map uses the low 4 pointer bits.
- R9: hst_rdata updates on the clock edge that samples a read strobe and holds until the next accepted read.
- R10: When hst_wr and hst_rd are both high in one cycle, only the write takes effect and hst_rdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe, one access per cycle |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 3 | External register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Registered host read data |

## Verification
If the pointer or the map-select bit holds a wrong value, the read of the next committed word comes back from the wrong location. This shows up on hst_rdata one cycle after the data register 0 read. A staging register that is not refreshed by a fetch, or that is disturbed by a foreign write, shows a mismatched byte on the following read of address 1 or 2. The sweeps therefore read every location back through all three data registers, and they recheck the channel map after the output map has been filled.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam logic [2:0] EA_DR0  = 3'd0;
  localparam logic [2:0] EA_DR1  = 3'd1;
  localparam logic [2:0] EA_DR2  = 3'd2;
  localparam logic [2:0] EA_CTRL = 3'd3;
  localparam logic [2:0] EA_PTR  = 3'd6;
  localparam int         CTRL_MAP_BIT = 5;
  localparam int         N_MAPS = 2;

  typedef enum logic {
    MAP_CHAN = 1'b0,
    MAP_OUT  = 1'b1
  } map_e;
endpackage

// File: rtl/idx_bank.sv
module idx_bank #(
  parameter int AW     = 8,
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/idx_regs.sv
module idx_regs
  import idx_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int IA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  input  logic [WORD_W-1:0] fetch_word,
  output logic [IA_W-1:0]   int_addr,
  output map_e              map_sel,
  output logic              commit,
  output logic [WORD_W-1:0] commit_word,
  output logic [7:0]        rdata
);
  localparam int HI_W = WORD_W - 16;

  logic [7:0]      dr1_q;
  logic [HI_W-1:0] dr2_q;
  logic [IA_W-1:0] ptr_q;
  map_e            map_q;
  logic [7:0]      rdata_q;
  logic [7:0]      rd_mux;
  logic            rd_only;
  logic            fetch;

  assign rd_only = rd & ~wr;
  assign fetch   = rd_only && (addr == EA_DR0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr1_q <= '0;
      dr2_q <= '0;
      ptr_q <= '0;
      map_q <= MAP_CHAN;
    end else if (wr) begin
      case (addr)
        EA_DR1:  dr1_q <= wdata;
        EA_DR2:  dr2_q <= wdata[HI_W-1:0];
        EA_CTRL: map_q <= map_e'(wdata[CTRL_MAP_BIT]);
        EA_PTR:  ptr_q <= wdata[IA_W-1:0];
        default: ;
      endcase
    end else if (fetch) begin
      dr1_q <= fetch_word[15:8];
      dr2_q <= fetch_word[WORD_W-1:16];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      EA_DR0:  rd_mux = fetch_word[7:0];
      EA_DR1:  rd_mux = dr1_q;
      EA_DR2:  rd_mux = {{(8-HI_W){1'b0}}, dr2_q};
      EA_CTRL: rd_mux[CTRL_MAP_BIT] = map_q;
      EA_PTR:  rd_mux = {{(8-IA_W){1'b0}}, ptr_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_only) rdata_q <= rd_mux;
  end

  assign int_addr    = ptr_q;
  assign map_sel     = map_q;
  assign commit      = wr && (addr == EA_DR0);
  assign commit_word = {dr2_q, dr1_q, wdata};
  assign rdata       = rdata_q;

  // R3: a data register 2 read never shows bits above the nibble
  a_r3_dr2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && addr == EA_DR2) |=> (rdata_q[7:4] == 4'h0));

  // R5 / R7: DR1 moves only on its own write or a fetch
  a_r7_dr1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && addr == EA_DR1) && !fetch) |=> $stable(dr1_q));

  // R2: the pointer changes only when address 6 is written
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == EA_PTR) |=> $stable(ptr_q));

  // R9 / R10: read data holds without an accepted read
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_only |=> $stable(rdata_q));

  // R6: a fetch reloads DR1 from the fetched word
  a_r6_fetch_dr1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> (dr1_q == $past(fetch_word[15:8])));
endmodule

// File: rtl/idx_port.sv
module idx_port
  import idx_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int CH_AW  = 8,
  parameter int OP_AW  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_wr,
  input  logic       hst_rd,
  input  logic [2:0] hst_addr,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata
);
  localparam int IA_W = (CH_AW > OP_AW) ? CH_AW : OP_AW;

  logic [IA_W-1:0]   int_addr;
  map_e              map_sel;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] fetch_word;
  logic [WORD_W-1:0] bank_rd [N_MAPS];
  logic [N_MAPS-1:0] bank_we;

  idx_regs #(.WORD_W(WORD_W), .IA_W(IA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (hst_wr),
    .rd         (hst_rd),
    .addr       (hst_addr),
    .wdata      (hst_wdata),
    .fetch_word (fetch_word),
    .int_addr   (int_addr),
    .map_sel    (map_sel),
    .commit     (commit),
    .commit_word(commit_word),
    .rdata      (hst_rdata)
  );

  for (genvar g = 0; g < N_MAPS; g++) begin : g_bank
    localparam int BAW = (g == 0) ? CH_AW : OP_AW;
    assign bank_we[g] = commit && (int'(map_sel) == g);
    idx_bank #(.AW(BAW), .WORD_W(WORD_W)) u_bank (
      .clk  (clk),
      .we   (bank_we[g]),
      .addr (int_addr[BAW-1:0]),
      .wdata(commit_word),
      .rdata(bank_rd[g])
    );
  end

  assign fetch_word = bank_rd[map_sel];

  // R8: at most one map is written per cycle
  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R5: no internal write without a data register 0 write
  a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we != '0) |-> (hst_wr && hst_addr == EA_DR0));
endmodule

// File: tb/tb_idx_port.sv
module tb_idx_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_wr = 1'b0;
  logic       hst_rd = 1'b0;
  logic [2:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idx_port dut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  function automatic logic [19:0] pat(int m, int a);
    return 20'(a * 32'h3A7 + m * 32'h5111 + 32'h1234);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    hst_rd = 1'b1; hst_addr = a;
    @(negedge clk);
    hst_rd = 1'b0;
    d = hst_rdata;
  endtask

  task automatic put(int a, logic [19:0] w);
    wr(3'd6, 8'(a));
    wr(3'd2, {4'hA, w[19:16]});
    wr(3'd1, w[15:8]);
    wr(3'd0, w[7:0]);
  endtask

  task automatic get_chk(string req, int a, logic [19:0] w);
    logic [7:0] d;
    wr(3'd6, 8'(a));
    rd(3'd0, d); chk(req, d, w[7:0]);
    rd(3'd1, d); chk(req, d, w[15:8]);
    rd(3'd2, d); chk(req, d, {4'h0, w[19:16]});
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", hst_rdata, 8'h00);
    rd(3'd6, d); chk("R1 ptr", d, 8'h00);
    rd(3'd3, d); chk("R1 ctrl", d, 8'h00);
    rd(3'd1, d); chk("R1 dr1", d, 8'h00);
    rd(3'd2, d); chk("R1 dr2", d, 8'h00);

    // R4 R6 R3: full sweep of the channel map
    wr(3'd3, 8'h00);
    for (int a = 0; a < 256; a++) put(a, pat(0, a));
    for (int a = 0; a < 256; a++) get_chk("R4 R6 chan", a, pat(0, a));

    // R8: output map, other control bits masked
    wr(3'd3, 8'hFF);
    rd(3'd3, d); chk("R8 ctrl readback", d, 8'h20);
    for (int a = 0; a < 16; a++) put(a, pat(1, a));
    for (int a = 0; a < 16; a++) get_chk("R8 out map", a, pat(1, a));
    put(16 + 3, pat(2, 3));
    get_chk("R8 out alias low bits", 3, pat(2, 3));
    wr(3'd3, 8'h00);
    for (int a = 0; a < 256; a++) get_chk("R8 chan isolated", a, pat(0, a));

    // R3: upper nibble of DR2 dropped
    wr(3'd2, 8'hF6);
    rd(3'd2, d); chk("R3 dr2 nibble", d, 8'h06);

    // R5: staging writes do not touch memory
    wr(3'd6, 8'd5);
    wr(3'd1, 8'h55);
    wr(3'd2, 8'h03);
    get_chk("R5 staged only", 5, pat(0, 5));

    // R7: DR0-only write keeps fetched upper bits
    get_chk("R7 prefetch", 20, pat(0, 20));
    wr(3'd6, 8'd21);
    wr(3'd0, 8'h77);
    get_chk("R7 narrow", 21, {pat(0, 20)[19:8], 8'h77});

    // R2: unused addresses
    wr(3'd6, 8'h2C);
    wr(3'd4, 8'hEE); wr(3'd5, 8'hEE); wr(3'd7, 8'hEE);
    rd(3'd4, d); chk("R2 addr4", d, 8'h00);
    rd(3'd5, d); chk("R2 addr5", d, 8'h00);
    rd(3'd7, d); chk("R2 addr7", d, 8'h00);
    rd(3'd6, d); chk("R2 ptr kept", d, 8'h2C);
    rd(3'd3, d); chk("R2 ctrl kept", d, 8'h00);

    // R9: rdata holds across writes
    rd(3'd6, d);
    wr(3'd1, 8'h11); wr(3'd2, 8'h01);
    chk("R9 hold", hst_rdata, 8'h2C);

    // R10: write wins over simultaneous read
    hst_wr = 1'b1; hst_rd = 1'b1; hst_addr = 3'd1; hst_wdata = 8'h9B;
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b0;
    chk("R10 rdata held", hst_rdata, 8'h2C);
    rd(3'd1, d); chk("R10 write taken", d, 8'h9B);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule